// File: doc/BRIEF.md
# Triggered Trace Capture Buffer

This block stores a group of observed signals, one word per clock, into an on-chip memory. Two trigger inputs, driven by a separate event detector, start and stop recording. Both pass through a fixed pipeline of `TRIG_LAT` registers before they take effect. The recorded window therefore sits at a known offset from the trigger pulses, and a host can align the samples it reads back.

A small register interface arms the block and picks the recording mode. In fill-once mode recording halts when the memory holds `DEPTH` words. In circular mode the oldest words are overwritten until a stop trigger arrives. When recording halts, the block takes a snapshot of the write position. Readback through a single data register then returns the valid samples from oldest to newest, whichever mode was used. A status word reports the state, the full and stopped flags, the mode and the number of valid entries.

Top module: `trace_capture`

## Requirements
- R1: After reset the status word reads 0: not armed, not recording, not full, not stopped, count 0.
- R2: A write to address 0 with `reg_wdata[0]`=1 arms the block and latches the mode from `reg_wdata[1]` (0 fill-once, 1 circular). It clears the count, full and stopped state and restarts the readback index.
- R3: While disarmed, a start trigger is ignored and the count stays unchanged.
- R4: With trigger latency L, a start sampled at edge S and a stop sampled at edge T record exactly the samples present at edges S+L through T+L-1.
- R5: In fill-once mode recording halts after `DEPTH` words with full and stopped set. Triggers arriving later change nothing.
- R6: In circular mode recording continues past `DEPTH` words, overwriting the oldest, until a stop takes effect. The count saturates at `DEPTH` and full is set once `DEPTH` words have been written.
- R7: Successive reads of address 2 after a stop return the stored samples from oldest to newest. In circular mode this means the `DEPTH` most recent samples.
- R8: A data read beyond the valid count, or while the block is not stopped, returns 0 and does not advance the readback index.
- R9: When start and stop take effect in the same cycle, stop wins. From the armed state the block goes to stopped with count 0.
- R10: Reads have one cycle of latency. Any address other than 2 returns the status word: bit0 armed and waiting, bit1 recording, bit2 full, bit3 stopped, bit4 mode, bits 16 and up the count.
- R11: A write to address 0 with `reg_wdata[0]`=0 disarms the block. Recording halts and the count stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_trig | input | 1 | Start recording request from the event detector |
| stop_trig | input | 1 | Stop recording request from the event detector |
| probe_data | input | WIDTH | Observed signal group, sampled every clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 2 data, others status) |
| reg_wdata | input | 2 | Control write data: bit0 arm, bit1 mode |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| full | output | 1 | Memory has held DEPTH valid words since arming |
| stopped | output | 1 | Recording has halted and readback is available |

## Verification
The assertions assume that the host changes the control register only with deliberate writes. Any cycle without a control write must leave a stopped or disarmed block's count untouched. The bench keeps to this: it issues control writes only between capture runs and pulses each trigger for one cycle. It leaves several idle cycles after each stop, so the delayed trigger has drained before the next arm. The capture length is swept across and beyond the memory depth in both modes, and every stored value is predicted from an incrementing probe pattern.

// File: rtl/trace_capture_pkg.sv
package trace_capture_pkg;

   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_ARMED = 2'd1,
      CAP_REC   = 2'd2,
      CAP_DONE  = 2'd3
   } cap_state_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   localparam int ST_ARMED_BIT = 0;
   localparam int ST_REC_BIT   = 1;
   localparam int ST_FULL_BIT  = 2;
   localparam int ST_STOP_BIT  = 3;
   localparam int ST_MODE_BIT  = 4;
   localparam int ST_CNT_LSB   = 16;

endpackage

// File: rtl/trace_trig_delay.sv
module trace_trig_delay #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_in,
   input  logic stop_in,
   output logic start_out,
   output logic stop_out
);

   generate
      if (LAT == 0) begin : g_direct
         assign start_out = start_in;
         assign stop_out  = stop_in;
      end else begin : g_pipe
         logic [LAT-1:0] st_sr;
         logic [LAT-1:0] sp_sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_sr <= '0;
               sp_sr <= '0;
            end else begin
               st_sr[0] <= start_in;
               sp_sr[0] <= stop_in;
               for (int i = 1; i < LAT; i++) begin
                  st_sr[i] <= st_sr[i-1];
                  sp_sr[i] <= sp_sr[i-1];
               end
            end
         end
         assign start_out = st_sr[LAT-1];
         assign stop_out  = sp_sr[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
   import trace_capture_pkg::*;
#(
   parameter int DEPTH  = 2048,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_req,
   input  logic             disarm_req,
   input  logic             mode_in,
   input  logic             start_d,
   input  logic             stop_d,
   input  logic             pop_req,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic             rd_en,
   output logic [AW-1:0]    rd_addr,
   output cap_state_t       state,
   output logic             full,
   output logic             mode,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    base;
   logic [CNT_W-1:0] rd_idx;
   logic             ctrl_hit;

   assign ctrl_hit = arm_req | disarm_req;
   assign wr_en    = !ctrl_hit && !stop_d &&
                     ((state == CAP_ARMED && start_d) || state == CAP_REC);
   assign wr_addr  = wr_ptr;
   assign rd_en    = pop_req && state == CAP_DONE && rd_idx < cnt;
   assign rd_addr  = base + rd_idx[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= CAP_IDLE;
         full   <= 1'b0;
         mode   <= 1'b0;
         cnt    <= '0;
         wr_ptr <= '0;
         base   <= '0;
         rd_idx <= '0;
      end else if (arm_req) begin
         state  <= CAP_ARMED;
         full   <= 1'b0;
         mode   <= mode_in;
         cnt    <= '0;
         wr_ptr <= '0;
         base   <= '0;
         rd_idx <= '0;
      end else if (disarm_req) begin
         state <= CAP_IDLE;
      end else begin
         if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt == CNT_LAST) begin
               full <= 1'b1;
               if (!mode) state <= CAP_DONE;
            end
         end
         case (state)
            CAP_ARMED: begin
               if (stop_d)       state <= CAP_DONE;
               else if (start_d) state <= CAP_REC;
            end
            CAP_REC: begin
               if (stop_d) begin
                  state <= CAP_DONE;
                  base  <= full ? wr_ptr : '0;
               end
            end
            CAP_DONE: begin
               if (rd_en) rd_idx <= rd_idx + 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/trace_capture.sv
module trace_capture
   import trace_capture_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int DEPTH    = 2048,
   parameter int TRIG_LAT = 2,
   localparam int AW      = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int RD_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_trig,
   input  logic             stop_trig,
   input  logic [WIDTH-1:0] probe_data,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [1:0]       reg_wdata,
   output logic [RD_W-1:0]  reg_rdata,
   output logic             full,
   output logic             stopped
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (WIDTH >= 1 && WIDTH <= RD_W)
         else $error("WIDTH must be between 1 and 32");
      assert (CNT_W <= RD_W - ST_CNT_LSB)
         else $error("DEPTH too large for the status count field");
      assert (TRIG_LAT >= 0)
         else $error("TRIG_LAT must not be negative");
   end

   logic             ctrl_wr;
   logic             arm_req;
   logic             disarm_req;
   logic             pop_req;
   logic             start_d;
   logic             stop_d;
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic             rd_en;
   logic [AW-1:0]    rd_addr;
   cap_state_t       state;
   logic             mode;
   logic [CNT_W-1:0] cnt;
   logic [WIDTH-1:0] mem_q;
   logic             sel_data_q;
   logic             data_ok_q;
   logic [RD_W-1:0]  stat_q;
   logic [RD_W-1:0]  stat_w;
   logic [RD_W-1:0]  data_w;

   assign ctrl_wr    = reg_wr && reg_addr == ADDR_CTRL;
   assign arm_req    = ctrl_wr && reg_wdata[0];
   assign disarm_req = ctrl_wr && !reg_wdata[0];
   assign pop_req    = reg_rd && reg_addr == ADDR_DATA;

   trace_trig_delay #(.LAT(TRIG_LAT)) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_in  (start_trig),
      .stop_in   (stop_trig),
      .start_out (start_d),
      .stop_out  (stop_d)
   );

   trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_req    (arm_req),
      .disarm_req (disarm_req),
      .mode_in    (reg_wdata[1]),
      .start_d    (start_d),
      .stop_d     (stop_d),
      .pop_req    (pop_req),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .state      (state),
      .full       (full),
      .mode       (mode),
      .cnt        (cnt)
   );

   trace_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (probe_data),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (mem_q)
   );

   assign stopped = state == CAP_DONE;

   always_comb begin
      stat_w                          = '0;
      stat_w[ST_ARMED_BIT]            = state == CAP_ARMED;
      stat_w[ST_REC_BIT]              = state == CAP_REC;
      stat_w[ST_FULL_BIT]             = full;
      stat_w[ST_STOP_BIT]             = stopped;
      stat_w[ST_MODE_BIT]             = mode;
      stat_w[ST_CNT_LSB +: CNT_W]     = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_data_q <= 1'b0;
         data_ok_q  <= 1'b0;
         stat_q     <= '0;
      end else if (reg_rd) begin
         sel_data_q <= pop_req;
         data_ok_q  <= rd_en;
         stat_q     <= stat_w;
      end
   end

   always_comb begin
      data_w            = '0;
      data_w[WIDTH-1:0] = mem_q;
   end

   assign reg_rdata = !sel_data_q ? stat_q : (data_ok_q ? data_w : '0);

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk
   import trace_capture_pkg::*;
#(
   parameter int DEPTH = 2048,
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_wr,
   input logic             arm_req,
   input cap_state_t       state,
   input logic [CNT_W-1:0] cnt,
   input logic             full,
   input logic             stopped,
   input logic             wr_en
);

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R6
   full_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> cnt == CNT_W'(DEPTH));

   // R2
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_req |=> (cnt == '0 && !full && !stopped));

   // R5
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !ctrl_wr) |=> (stopped && $stable(cnt)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAP_IDLE && !ctrl_wr) |=> $stable(cnt));

   // R5
   no_write_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> !wr_en);

endmodule

bind trace_capture trace_capture_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ctrl_wr (ctrl_wr),
   .arm_req (arm_req),
   .state   (state),
   .cnt     (cnt),
   .full    (full),
   .stopped (stopped),
   .wr_en   (wr_en)
);

// File: tb/trace_capture_tb.sv
`timescale 1ns/1ps
module trace_capture_tb;

   localparam int W   = 8;
   localparam int D   = 8;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_trig = 1'b0;
   logic          stop_trig = 1'b0;
   logic [W-1:0]  probe_data = '0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [1:0]    reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          full;
   logic          stopped;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   trace_capture #(.WIDTH(W), .DEPTH(D), .TRIG_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_trig(start_trig), .stop_trig(stop_trig),
      .probe_data(probe_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .full(full), .stopped(stopped)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic st, input logic sp, input logic wr,
                        input logic rd, input logic [1:0] a, input logic [1:0] wd);
      @(negedge clk);
      start_trig = st; stop_trig = sp; reg_wr = wr; reg_rd = rd;
      reg_addr = a; reg_wdata = wd;
      probe_data = probe_data + 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 2'd0, 2'd0);
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
      drive(0, 0, 0, 1, a, 2'd0);
      drive(0, 0, 0, 0, 2'd0, 2'd0);
      v = reg_rdata;
   endtask

   function automatic logic [31:0] stat_word(int cnt, bit f, bit s, bit m, bit armed, bit rec);
      return (32'(cnt) << 16) | (m ? 32'h10 : 0) | (s ? 32'h8 : 0) |
             (f ? 32'h4 : 0) | (rec ? 32'h2 : 0) | (armed ? 32'h1 : 0);
   endfunction

   // capture with start at P and stop at P+n, then read everything back
   task automatic run(input bit m, input int n);
      logic [31:0] v;
      logic [W-1:0] p, q, first;
      int c;
      drive(0, 0, 1, 0, 2'd0, {m, 1'b1});
      drive(1, 0, 0, 0, 2'd0, 2'd0);
      p = probe_data;
      idle(n - 1);
      drive(0, 1, 0, 0, 2'd0, 2'd0);
      q = probe_data;
      idle(4);
      c = (n < D) ? n : D;
      first = m ? W'(q + LAT - c) : W'(p + LAT);
      rd_reg(2'd1, v);
      check(m ? "R6 status after circular run" : "R5 status after fill run",
            v, stat_word(c, n >= D, 1, m, 0, 0));
      for (int i = 0; i < c; i++) begin
         rd_reg(2'd2, v);
         check(m ? "R7 circular readback (R4 window)" : "R7 fill readback (R4 window)",
               v, {24'd0, W'(first + i)});
      end
      rd_reg(2'd2, v);
      check("R8 read beyond valid count", v, 32'd0);
      rd_reg(2'd2, v);
      check("R8 index not advanced past count", v, 32'd0);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 / R10
      rd_reg(2'd1, v);
      check("R1 reset status", v, 32'd0);
      rd_reg(2'd3, v);
      check("R10 non-data address returns status", v, 32'd0);

      // R3: start while disarmed
      drive(1, 0, 0, 0, 2'd0, 2'd0);
      idle(6);
      rd_reg(2'd1, v);
      check("R3 start ignored while disarmed", v, 32'd0);

      // R2: arm, then R8 data read while armed
      drive(0, 0, 1, 0, 2'd0, 2'd1);
      rd_reg(2'd1, v);
      check("R2 armed status", v, stat_word(0, 0, 0, 0, 1, 0));
      rd_reg(2'd2, v);
      check("R8 data read while not stopped", v, 32'd0);

      // R4..R8 sweep over both modes and lengths below, at and beyond depth
      for (int m = 0; m < 2; m++)
         for (int n = 1; n <= D + 4; n++)
            run(m[0], n);

      // R5: a trigger after a fill-once capture has filled changes nothing
      run(1'b0, D + 2);
      drive(1, 0, 0, 0, 2'd0, 2'd0);
      idle(5);
      rd_reg(2'd1, v);
      check("R5 later start ignored after full", v, stat_word(D, 1, 1, 0, 0, 0));

      // R9: start and stop together
      drive(0, 0, 1, 0, 2'd0, 2'd1);
      drive(1, 1, 0, 0, 2'd0, 2'd0);
      idle(4);
      rd_reg(2'd1, v);
      check("R9 stop wins over start", v, stat_word(0, 0, 1, 0, 0, 0));
      rd_reg(2'd2, v);
      check("R9 nothing recorded", v, 32'd0);

      // R11: disarm mid-recording
      drive(0, 0, 1, 0, 2'd0, 2'd3);
      drive(1, 0, 0, 0, 2'd0, 2'd0);
      idle(3);
      drive(0, 0, 1, 0, 2'd0, 2'd0);
      idle(4);
      rd_reg(2'd1, v);
      check("R11 disarm halts recording", v, stat_word(2, 0, 0, 1, 0, 0));
      idle(5);
      rd_reg(2'd1, v);
      check("R11 count frozen after disarm", v, stat_word(2, 0, 0, 1, 0, 0));
      check("R11 stopped pin low when disarmed", {31'd0, stopped}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule